// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external serial master read and write an on-chip byte-wide register space over a four-wire serial link. The link uses clock, active-low select, master-out data and slave-out data. A transaction starts when the select falls and ends when it rises. The master first sends a 3-bit opcode, then a 24-bit address, then five turnaround bits. One or more data bytes follow. Every field is sent most significant bit first. The master changes its data so that the slave can sample it on the rising serial clock edge. The slave changes its output after each falling serial clock edge. The serial clock rests low between transactions.

All logic runs on the system clock. Select, serial clock and master data each pass through a two-flop synchroniser. Serial clock edges are then detected in the system domain, so the serial clock must run no faster than a quarter of the system clock.

On the register side the block drives a simple synchronous bus. It issues single-cycle read and write strobes together with a 16-bit address and a write byte. Read data must be valid in the cycle after the read strobe. While select stays low after a data byte, further bytes are transferred at consecutive addresses.

Top module: `spi_reg_slave`

## Requirements
- R1: Out of reset, `spi_sdo_oe`, `reg_wr` and `reg_rd` are low.
- R2: Opcode `011` is a read. After the 27th rising serial clock edge, `reg_rd` pulses with `reg_addr` equal to address bits 15..0. The byte is then shifted out on `spi_sdo` MSB first, and each bit changes only after a falling serial clock edge. D7 is present before the first data-phase rising edge.
- R3: Opcode `010` is a write. After the 8th data bit is sampled on a rising edge, `reg_wr` pulses for one cycle. `reg_wdata` carries the byte, assembled MSB first, and `reg_addr` carries the current address.
- R4: Address bits 23..16 have no effect on `reg_addr` or on the data transferred.
- R5: The five turnaround bits have no effect on the transfer.
- R6: In a write burst, each further 8 serial clocks produce another `reg_wr`, with `reg_addr` one higher than for the previous byte.
- R7: In a read burst, during the last bit of every byte a `reg_rd` is issued for the next address. An N-byte read therefore issues N+1 read strobes, at consecutive addresses starting from the frame address.
- R8: `spi_sdo_oe` is low during the opcode, address and turnaround bits and throughout a write. It is high during the read data bits. It returns low once select has risen.
- R9: An opcode other than `011` or `010` produces no strobe, and `spi_sdo_oe` stays low until select rises.
- R10: If select rises before a data byte is complete, the partial byte is discarded with no `reg_wr`. The next frame is decoded normally.
- R11: The 16-bit address counter wraps from 0xFFFF to 0x0000 within a burst.
- R12: `reg_wr` and `reg_rd` are never high together, and each is high for one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master, low when idle |
| spi_cs_n | input | 1 | Active-low select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_sdo | output | 1 | Serial data to the master |
| spi_sdo_oe | output | 1 | Output enable for the pad driver of `spi_sdo`; low means high impedance |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid in the cycle after `reg_rd` |

## Verification
The bench builds the block with its default parameters: a 16-bit decoded address, 24 address bits on the wire, 8-bit data, a 3-bit opcode, 5 turnaround bits and two synchroniser stages. Because the decoded address is 16 bits, a two-byte burst that starts at 0xFFFF reaches the counter wrap directly. Each serial clock half-period lasts four system clocks, so the serial clock runs at one eighth of the system clock. That setting still allows the prefetch read strobe, issued before the last bit of a byte, to deliver the next byte before the falling edge that presents its first bit.

// File: rtl/spi_reg_pkg.sv
// Shared types and opcode constants for the serial register slave.
// Assumes opcodes are three bits wide and transmitted MSB first.
package spi_reg_pkg;
    localparam int OPC_W = 3;
    localparam logic [OPC_W-1:0] OPC_READ  = 3'b011;
    localparam logic [OPC_W-1:0] OPC_WRITE = 3'b010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_TURN,
        PH_DATA,
        PH_SKIP
    } phase_t;
endpackage

// File: rtl/spi_reg_sync.sv
// Multi-bit input synchroniser: each bit passes through its own chain of
// STAGES flops. Assumes the bits are independent asynchronous levels.
module spi_reg_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;

        // shift the asynchronous level through the flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
            else        chain <= {chain[STAGES-2:0], d[i]};
        end

        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_reg_edge.sv
// Edge detector for the synchronised serial clock. Produces one-cycle
// rise and fall pulses. Assumes the input is already in the clk domain.
module spi_reg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    output logic sck_rise,
    output logic sck_fall
);
    logic sck_q;

    // remember the previous serial clock level (idle level is low)
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_q;
    assign sck_fall = ~sck_s & sck_q;
endmodule

// File: rtl/spi_reg_engine.sv
// Frame engine: decodes opcode, address and turnaround, then moves data
// bytes between the serial line and the register bus, with burst address
// increment and read prefetch. Assumes synchronised inputs, edge pulses
// at least two clk cycles apart, and read data valid the cycle after reg_rd.
module spi_reg_engine
    import spi_reg_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int WIRE_ADDR_W = 24,
    parameter int TURN_W      = 5,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic              sck_rise,
    input  logic              sck_fall,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int CNT_W = $clog2(WIRE_ADDR_W);
    localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(OPC_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(WIRE_ADDR_W - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    phase_t             phase;
    logic [CNT_W-1:0]   cnt;
    logic [ADDR_W-1:0]  sh;
    logic [ADDR_W-1:0]  sh_next;
    logic [ADDR_W-1:0]  addr;
    logic               is_read;
    logic [DATA_W-1:0]  tx;
    logic [DATA_W-1:0]  rd_buf;
    logic               rd_pend;
    logic [OPC_W-1:0]   opc_now;

    assign sh_next = {sh[ADDR_W-2:0], mosi_s};
    assign opc_now = sh_next[OPC_W-1:0];

    // capture read data one cycle after each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            rd_buf  <= '0;
        end else begin
            rd_pend <= reg_rd;
            if (rd_pend) rd_buf <= reg_rdata;
        end
    end

    // frame sequencing, shifting and register bus strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            sh        <= '0;
            addr      <= '0;
            is_read   <= 1'b0;
            tx        <= '0;
            sdo       <= 1'b0;
            sdo_oe    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (cs_n_s) begin
                phase  <= PH_IDLE;
                cnt    <= '0;
                sdo_oe <= 1'b0;
            end else begin
                unique case (phase)
                    PH_IDLE: begin
                        phase   <= PH_OPC;
                        cnt     <= '0;
                        is_read <= 1'b0;
                    end
                    PH_OPC: if (sck_rise) begin
                        sh <= sh_next;
                        if (cnt == OPC_LAST) begin
                            cnt <= '0;
                            if (opc_now == OPC_READ) begin
                                phase   <= PH_ADDR;
                                is_read <= 1'b1;
                            end else if (opc_now == OPC_WRITE) begin
                                phase   <= PH_ADDR;
                                is_read <= 1'b0;
                            end else begin
                                phase   <= PH_SKIP;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_ADDR: if (sck_rise) begin
                        sh <= sh_next;
                        if (cnt == ADDR_LAST) begin
                            cnt   <= '0;
                            phase <= PH_TURN;
                            addr  <= sh_next;
                            if (is_read) begin
                                reg_rd   <= 1'b1;
                                reg_addr <= sh_next;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_TURN: if (sck_rise) begin
                        if (cnt == TURN_LAST) begin
                            cnt   <= '0;
                            phase <= PH_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (sck_rise) begin
                            sh <= sh_next;
                            if (cnt == DATA_LAST) begin
                                cnt  <= '0;
                                addr <= addr + 1'b1;
                                if (!is_read) begin
                                    reg_wr    <= 1'b1;
                                    reg_addr  <= addr;
                                    reg_wdata <= sh_next[DATA_W-1:0];
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end else if (sck_fall && is_read) begin
                            sdo_oe <= 1'b1;
                            if (cnt == '0) begin
                                sdo <= rd_buf[DATA_W-1];
                                tx  <= {rd_buf[DATA_W-2:0], 1'b0};
                            end else begin
                                sdo <= tx[DATA_W-1];
                                tx  <= {tx[DATA_W-2:0], 1'b0};
                            end
                            if (cnt == DATA_LAST) begin
                                reg_rd   <= 1'b1;
                                reg_addr <= addr + 1'b1;
                            end
                        end
                    end
                    PH_SKIP: ;
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // R12: strobes are exclusive and last one cycle
    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
    assert_wr_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    assert_rd_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);
    // R3: a write strobe follows a sampled rising serial clock edge
    assert_wr_after_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(sck_rise));
    // R2: serial output only changes after a falling serial clock edge
    assert_sdo_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(sdo));
    // R8: output enable drops once select is seen high
    assert_oe_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !sdo_oe);
    // R9: an unknown opcode keeps the block silent
    assert_skip_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP) |-> (!reg_wr && !reg_rd && !sdo_oe));
endmodule

// File: rtl/spi_reg_slave.sv
// Top level of the serial register slave: synchronises the serial pins,
// detects serial clock edges and runs the frame engine. Assumes the serial
// clock runs at no more than a quarter of clk.
module spi_reg_slave #(
    parameter int ADDR_W      = 16,
    parameter int WIRE_ADDR_W = 24,
    parameter int TURN_W      = 5,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int PIN_N = 3;

    logic [PIN_N-1:0] pins_s;
    logic             cs_n_s;
    logic             sck_s;
    logic             mosi_s;
    logic             sck_rise;
    logic             sck_fall;

    spi_reg_sync #(
        .WIDTH  (PIN_N),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({spi_cs_n, spi_sck, spi_mosi}),
        .q    (pins_s)
    );

    assign {cs_n_s, sck_s, mosi_s} = pins_s;

    spi_reg_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (sck_s),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall)
    );

    spi_reg_engine #(
        .ADDR_W     (ADDR_W),
        .WIRE_ADDR_W(WIRE_ADDR_W),
        .TURN_W     (TURN_W),
        .DATA_W     (DATA_W)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (cs_n_s),
        .mosi_s   (mosi_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_rdata(reg_rdata),
        .sdo      (spi_sdo),
        .sdo_oe   (spi_sdo_oe)
    );
endmodule

// File: tb/spi_reg_slave_bench.sv
// Scoreboard bench: frame tasks queue the expected writes, a monitor pops
// and compares them, and read bytes are compared against an address model.
module spi_reg_slave_bench;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_sdo;
    logic        spi_sdo_oe;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_wr;
    logic        reg_rd;
    logic [7:0]  reg_rdata = 8'h00;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [23:0] exp_wr_q[$];
    logic [15:0] rd_addr_q[$];
    logic [7:0]  wbuf[0:7];
    logic        oe_bad;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    spi_reg_slave u_spi_reg_slave (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] rmodel(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // register model: one-cycle read latency
    always @(posedge clk) if (reg_rd) reg_rdata <= rmodel(reg_addr);

    // monitor: compare write strobes with the scoreboard, log read strobes
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                wr_cnt++;
                if (exp_wr_q.size() == 0) chk(1'b0, "R3 unexpected write", {reg_addr, reg_wdata}, 0);
                else begin
                    logic [23:0] e;
                    e = exp_wr_q.pop_front();
                    chk({reg_addr, reg_wdata} == e, "R3/R6 write addr+data", {reg_addr, reg_wdata}, e);
                end
            end
            if (reg_rd) begin
                rd_cnt++;
                rd_addr_q.push_back(reg_addr);
            end
        end
    end

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic so, output logic oe);
        spi_mosi = b;
        half_wait();
        so = spi_sdo;
        oe = spi_sdo_oe;
        spi_sck = 1'b1;
        half_wait();
        spi_sck = 1'b0;
    endtask

    // one frame; read bytes are checked against the model at each byte end
    task automatic frame(input logic [2:0] op, input logic [23:0] a, input logic [4:0] ta,
                         input int nbits, input bit is_rd);
        logic so, oe;
        logic [7:0] rbyte;
        oe_bad = 1'b0;
        rbyte = 8'h00;
        spi_cs_n = 1'b0;
        half_wait();
        for (int i = 2; i >= 0; i--) begin bit_io(op[i], so, oe); if (oe) oe_bad = 1'b1; end
        for (int i = 23; i >= 0; i--) begin bit_io(a[i], so, oe); if (oe) oe_bad = 1'b1; end
        for (int i = 4; i >= 0; i--) begin bit_io(ta[i], so, oe); if (oe) oe_bad = 1'b1; end
        chk(!oe_bad, "R8 oe low before data", oe_bad, 0);
        for (int k = 0; k < nbits; k++) begin
            int bi;
            bi = 7 - (k % 8);
            bit_io(wbuf[k / 8][bi], so, oe);
            rbyte[bi] = so;
            if (is_rd && !oe) oe_bad = 1'b1;
            if (!is_rd && oe) oe_bad = 1'b1;
            if (is_rd && bi == 0) begin
                logic [15:0] ea;
                ea = a[15:0] + 16'(k / 8);
                chk(rbyte == rmodel(ea), "R2/R7 read byte", rbyte, rmodel(ea));
            end
        end
        if (nbits > 0) chk(!oe_bad, "R8 oe during data", oe_bad, 0);
        half_wait();
        spi_cs_n = 1'b1;
        half_wait();
        half_wait();
        chk(!spi_sdo_oe, "R8 oe low after select rise", spi_sdo_oe, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w0, r0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!spi_sdo_oe && !reg_wr && !reg_rd, "R1 reset outputs", {spi_sdo_oe, reg_wr, reg_rd}, 0);
        repeat (6) @(negedge clk);

        // R3: single write
        wbuf[0] = 8'hA7;
        exp_wr_q.push_back({16'h1234, 8'hA7});
        frame(3'b010, 24'h001234, 5'h00, 8, 1'b0);
        chk(wr_cnt == 1, "R3 single write count", wr_cnt, 1);

        // R4/R5: junk high address bits and turnaround bits on a write
        wbuf[0] = 8'h5C;
        exp_wr_q.push_back({16'h0BEE, 8'h5C});
        frame(3'b010, 24'hC30BEE, 5'h15, 8, 1'b0);
        chk(wr_cnt == 2, "R4/R5 write count", wr_cnt, 2);

        // R2: single read, R4/R5 with junk
        rd_addr_q.delete();
        r0 = rd_cnt;
        wbuf[0] = 8'h00;
        frame(3'b011, 24'hA52468, 5'h1F, 8, 1'b1);
        chk(rd_addr_q.size() > 0 && rd_addr_q[0] == 16'h2468, "R2/R4 read address", rd_addr_q[0], 16'h2468);

        // R6: burst write of three bytes
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        exp_wr_q.push_back({16'h4000, 8'h11});
        exp_wr_q.push_back({16'h4001, 8'h22});
        exp_wr_q.push_back({16'h4002, 8'h33});
        w0 = wr_cnt;
        frame(3'b010, 24'h004000, 5'h00, 24, 1'b0);
        chk(wr_cnt - w0 == 3, "R6 burst write count", wr_cnt - w0, 3);

        // R7: burst read of three bytes, N+1 strobes at consecutive addresses
        rd_addr_q.delete();
        r0 = rd_cnt;
        wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h00;
        frame(3'b011, 24'h0077F0, 5'h00, 24, 1'b1);
        chk(rd_cnt - r0 == 4, "R7 read strobe count", rd_cnt - r0, 4);
        for (int i = 0; i < 4 && i < rd_addr_q.size(); i++)
            chk(rd_addr_q[i] == 16'h77F0 + 16'(i), "R7 prefetch address", rd_addr_q[i], 16'h77F0 + 16'(i));

        // R11: wrap in a write burst and in a read burst
        wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
        exp_wr_q.push_back({16'hFFFF, 8'hE1});
        exp_wr_q.push_back({16'h0000, 8'hE2});
        frame(3'b010, 24'h00FFFF, 5'h00, 16, 1'b0);
        rd_addr_q.delete();
        frame(3'b011, 24'h12FFFF, 5'h00, 16, 1'b1);
        chk(rd_addr_q.size() >= 2 && rd_addr_q[1] == 16'h0000, "R11 read wrap address", rd_addr_q[1], 0);

        // R9: unknown opcode with data bits
        w0 = wr_cnt; r0 = rd_cnt;
        wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
        frame(3'b111, 24'h000100, 5'h00, 16, 1'b0);
        chk(wr_cnt == w0 && rd_cnt == r0, "R9 no strobes", wr_cnt + rd_cnt, w0 + r0);
        frame(3'b001, 24'h000100, 5'h00, 16, 1'b0);
        chk(wr_cnt == w0 && rd_cnt == r0, "R9 no strobes opcode 001", wr_cnt + rd_cnt, w0 + r0);

        // R10: abort after 12 data bits: first byte written, partial discarded
        w0 = wr_cnt;
        wbuf[0] = 8'h6D; wbuf[1] = 8'h99;
        exp_wr_q.push_back({16'h0200, 8'h6D});
        frame(3'b010, 24'h000200, 5'h00, 12, 1'b0);
        chk(wr_cnt - w0 == 1, "R10 partial byte discarded", wr_cnt - w0, 1);
        wbuf[0] = 8'h42;
        exp_wr_q.push_back({16'h0300, 8'h42});
        frame(3'b010, 24'h000300, 5'h00, 8, 1'b0);
        chk(wr_cnt - w0 == 2, "R10 next frame decoded", wr_cnt - w0, 2);

        repeat (10) @(negedge clk);
        chk(exp_wr_q.size() == 0, "R3/R6 scoreboard drained", exp_wr_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule